// File: doc/BRIEF.md
# 40-bit Accumulator Compare and Shift Unit

This block is the accumulator datapath of a multiply-accumulate coprocessor. It holds a 40-bit accumulator made of an 8-bit extension byte on top of a 16-bit high word and a 16-bit low word. It also holds a status word of arithmetic flags and a one-bit control register that enables saturation mode. One opcode is executed per clock. The supported operations are loading the accumulator from two 16-bit operands, comparing it against a sign-extended 32-bit operand, and shifting it right either logically or arithmetically by one to eight places.

Compare subtracts the operand from the accumulator, in that order. It sets the flags from the difference and leaves the accumulator as it was. Right shifts always act on all 40 bits and are never saturated. The extension-used flag is evaluated the same way whether saturation mode is on or off. The low byte of the status word mirrors the extension byte and can be written, so software can place a value directly in the extension byte. The multiplier array sits outside this block.

Top module: `mac_acc_unit`

## Requirements
- R1: After reset the accumulator is zero, the status word is 0x0000 and the saturation enable reads 0.
- R2: Opcode 1 (load) sets the accumulator to {opb_i, opa_i} sign-extended from bit 31 to 40 bits. It then sets N = bit 39, Z = (result is zero), C = 0, SV = 0 and E = 0.
- R3: Opcode 2 (compare) forms D = acc − X, where X is {opb_i, opa_i} sign-extended to 40 bits. The accumulator is left unchanged. The flags are set as follows: C = borrow (acc < X as 40-bit unsigned values), N = D[39], Z = (D is zero), SV = (signed overflow of the 40-bit subtraction). E is unchanged.
- R4: Opcode 3 (logical right shift) shifts all 40 bits right by shamt_i+1 places, where shamt_i is a 3-bit field giving counts 1 to 8, and fills bit 39 with zeros. C becomes the last bit shifted out, SV is cleared, and N and Z follow the result.
- R5: Opcode 4 (arithmetic right shift) behaves as R4 but fills from the left with copies of the original bit 39.
- R6: Shift results and flags are the same whether the saturation enable is 0 or 1. No shift result is ever clamped.
- R7: After a load or a shift, E = 1 exactly when accumulator bits 39:31 are not all equal. This holds with saturation mode enabled as well.
- R8: The status word is laid out as follows: bits 7:0 = accumulator bits 39:32, bit 8 = N, bit 9 = Z, bit 10 = C, bit 11 = E, bit 12 = SV, bit 13 = SL. Bits 15:14 always read 0.
- R9: When sw_we_i is 1, the accumulator extension byte takes sw_wdata_i[7:0] and each flag takes its bit from sw_wdata_i as laid out in R8. In that cycle opcode execution is suppressed.
- R10: SL is set by any operation that sets SV. After that it changes only through a status-word write.
- R11: Opcode 0 and the undefined opcodes 5 to 7 leave the accumulator and the status word unchanged.
- R12: When ctl_we_i is 1, the saturation enable takes ctl_sat_i. The new value appears on sat_en_o after the clock edge. This write is independent of the opcode and of status writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Opcode: 0 none, 1 load, 2 compare, 3 logical shift, 4 arithmetic shift |
| opa_i | input | 16 | First operand (bits 15:0 of load/compare value) |
| opb_i | input | 16 | Second operand (bits 31:16 of load/compare value) |
| shamt_i | input | 3 | Shift count minus one |
| sw_we_i | input | 1 | Status-word write strobe |
| sw_wdata_i | input | 16 | Status-word write data |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_sat_i | input | 1 | Saturation enable write data |
| acc_o | output | 40 | Accumulator |
| status_o | output | 16 | Status word |
| sat_en_o | output | 1 | Saturation enable |

## Verification
Compares are run with an operand smaller than, equal to and larger than the accumulator. These cases separate the borrow polarity from the reversed-operand mistake and exercise Z on its own. A compare of a large positive accumulator against −1 produces signed overflow, which shows that SV and the sticky SL behave differently once a later load clears SV. Shifts are run on a value with a positive 0x7F extension byte and on a negative value, at counts of 1 and 8, in both fill modes and with saturation both on and off. These runs tell zero-fill from sign-fill, test E when saturation is enabled, and confirm that the results are never clamped. A status write issued together with a load, and an undefined opcode, show that the suppressed or ignored operation leaves no trace at the ports.

// File: rtl/mac_acc_pkg.sv
package mac_acc_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_LOAD = 3'd1,
        OP_CMP  = 3'd2,
        OP_LSR  = 3'd3,
        OP_ASR  = 3'd4
    } op_e;

    // status word bit positions above the extension-byte mirror
    localparam int ST_N  = 8;
    localparam int ST_Z  = 9;
    localparam int ST_C  = 10;
    localparam int ST_E  = 11;
    localparam int ST_SV = 12;
    localparam int ST_SL = 13;
    localparam int ST_W  = 16;

    typedef struct packed {
        logic sl;
        logic sv;
        logic e;
        logic c;
        logic z;
        logic n;
    } flags_t;

endpackage

// File: rtl/mac_res_eval.sv
module mac_res_eval #(
    parameter int ACC_W = 40,
    parameter int EXT_W = 8
) (
    input  logic [ACC_W-1:0] val_i,
    output logic             ext_used_o,
    output logic             neg_o,
    output logic             zero_o
);
    localparam int TOP_W = EXT_W + 1;

    logic [TOP_W-1:0] top_bits;

    always_comb begin
        top_bits   = val_i[ACC_W-1 -: TOP_W];
        ext_used_o = (top_bits != '0) && (top_bits != '1);
        neg_o      = val_i[ACC_W-1];
        zero_o     = (val_i == '0);
    end
endmodule

// File: rtl/mac_cmp_unit.sv
module mac_cmp_unit #(
    parameter int ACC_W = 40
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] opx_i,
    output logic             borrow_o,
    output logic             neg_o,
    output logic             zero_o,
    output logic             ovf_o
);
    logic [ACC_W:0] wide;

    always_comb begin
        wide     = {1'b0, acc_i} - {1'b0, opx_i};
        borrow_o = wide[ACC_W];
        neg_o    = wide[ACC_W-1];
        zero_o   = (wide[ACC_W-1:0] == '0);
        ovf_o    = (acc_i[ACC_W-1] != opx_i[ACC_W-1]) &&
                   (wide[ACC_W-1] != acc_i[ACC_W-1]);
    end
endmodule

// File: rtl/mac_shift_unit.sv
module mac_shift_unit #(
    parameter int ACC_W = 40,
    parameter int SH_W  = 3
) (
    input  logic [ACC_W-1:0] val_i,
    input  logic [SH_W-1:0]  cnt_m1_i,
    input  logic             arith_i,
    output logic [ACC_W-1:0] res_o,
    output logic             cout_o
);
    localparam int MAX_SH = 1 << SH_W;

    logic             fill;
    logic [ACC_W-1:0] cand [MAX_SH];
    logic             cbit [MAX_SH];

    assign fill = arith_i & val_i[ACC_W-1];

    for (genvar k = 0; k < MAX_SH; k++) begin : g_amt
        localparam int AMT = k + 1;
        assign cand[k] = {{AMT{fill}}, val_i[ACC_W-1:AMT]};
        assign cbit[k] = val_i[AMT-1];
    end

    assign res_o  = cand[cnt_m1_i];
    assign cout_o = cbit[cnt_m1_i];
endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
    import mac_acc_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int EXT_W  = 8,
    parameter int SH_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               op_i,
    input  logic [WORD_W-1:0]        opa_i,
    input  logic [WORD_W-1:0]        opb_i,
    input  logic [SH_W-1:0]          shamt_i,
    input  logic                     sw_we_i,
    input  logic [ST_W-1:0]          sw_wdata_i,
    input  logic                     ctl_we_i,
    input  logic                     ctl_sat_i,
    output logic [2*WORD_W+EXT_W-1:0] acc_o,
    output logic [ST_W-1:0]          status_o,
    output logic                     sat_en_o
);
    localparam int ACC_W = 2 * WORD_W + EXT_W;
    localparam int OPD_W = 2 * WORD_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        flags_t           fl;
        logic             sat;
    } state_t;

    state_t st_d, st_q;

    logic [ACC_W-1:0] opx;
    logic [ACC_W-1:0] sh_res;
    logic             sh_cout;
    logic             cmp_c, cmp_n, cmp_z, cmp_v;
    logic             ld_e, ld_n, ld_z;
    logic             sh_e, sh_n, sh_z;
    logic             do_asr;

    assign opx    = {{EXT_W{opb_i[WORD_W-1]}}, opb_i, opa_i};
    assign do_asr = (op_i == OP_ASR);

    mac_cmp_unit #(.ACC_W(ACC_W)) u_cmp (
        .acc_i    (st_q.acc),
        .opx_i    (opx),
        .borrow_o (cmp_c),
        .neg_o    (cmp_n),
        .zero_o   (cmp_z),
        .ovf_o    (cmp_v)
    );

    mac_shift_unit #(.ACC_W(ACC_W), .SH_W(SH_W)) u_shift (
        .val_i    (st_q.acc),
        .cnt_m1_i (shamt_i),
        .arith_i  (do_asr),
        .res_o    (sh_res),
        .cout_o   (sh_cout)
    );

    mac_res_eval #(.ACC_W(ACC_W), .EXT_W(EXT_W)) u_ld_eval (
        .val_i      (opx),
        .ext_used_o (ld_e),
        .neg_o      (ld_n),
        .zero_o     (ld_z)
    );

    mac_res_eval #(.ACC_W(ACC_W), .EXT_W(EXT_W)) u_sh_eval (
        .val_i      (sh_res),
        .ext_used_o (sh_e),
        .neg_o      (sh_n),
        .zero_o     (sh_z)
    );

    always_comb begin
        st_d = st_q;
        if (sw_we_i) begin
            st_d.acc[ACC_W-1 -: EXT_W] = sw_wdata_i[EXT_W-1:0];
            st_d.fl.n  = sw_wdata_i[ST_N];
            st_d.fl.z  = sw_wdata_i[ST_Z];
            st_d.fl.c  = sw_wdata_i[ST_C];
            st_d.fl.e  = sw_wdata_i[ST_E];
            st_d.fl.sv = sw_wdata_i[ST_SV];
            st_d.fl.sl = sw_wdata_i[ST_SL];
        end else begin
            case (op_i)
                OP_LOAD: begin
                    st_d.acc   = opx;
                    st_d.fl.n  = ld_n;
                    st_d.fl.z  = ld_z;
                    st_d.fl.e  = ld_e;
                    st_d.fl.c  = 1'b0;
                    st_d.fl.sv = 1'b0;
                end
                OP_CMP: begin
                    st_d.fl.n  = cmp_n;
                    st_d.fl.z  = cmp_z;
                    st_d.fl.c  = cmp_c;
                    st_d.fl.sv = cmp_v;
                    st_d.fl.sl = st_q.fl.sl | cmp_v;
                end
                OP_LSR, OP_ASR: begin
                    st_d.acc   = sh_res;
                    st_d.fl.n  = sh_n;
                    st_d.fl.z  = sh_z;
                    st_d.fl.e  = sh_e;
                    st_d.fl.c  = sh_cout;
                    st_d.fl.sv = 1'b0;
                end
                default: ;
            endcase
        end
        if (ctl_we_i) begin
            st_d.sat = ctl_sat_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_o                = '0;
        status_o[EXT_W-1:0]     = st_q.acc[ACC_W-1 -: EXT_W];
        status_o[ST_N]          = st_q.fl.n;
        status_o[ST_Z]          = st_q.fl.z;
        status_o[ST_C]          = st_q.fl.c;
        status_o[ST_E]          = st_q.fl.e;
        status_o[ST_SV]         = st_q.fl.sv;
        status_o[ST_SL]         = st_q.fl.sl;
    end

    assign acc_o    = st_q.acc;
    assign sat_en_o = st_q.sat;
endmodule

// File: rtl/mac_acc_chk.sv
module mac_acc_chk
    import mac_acc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  op_i,
    input logic        sw_we_i,
    input logic [39:0] acc_o,
    input logic [15:0] status_o
);
    // R3: compare never alters the accumulator
    p_cmp_keeps_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP && !sw_we_i) |=> (acc_o == $past(acc_o)));

    // R7: after a shift, E matches the significance of bits 39:31
    p_shift_ext_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_LSR || op_i == OP_ASR) && !sw_we_i) |=>
        (status_o[ST_E] == ((acc_o[39:31] != 9'h000) && (acc_o[39:31] != 9'h1FF))));

    // R10: SL only drops through a status write
    p_sticky_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[ST_SL] && !sw_we_i) |=> status_o[ST_SL]);

    // R10: an overflow from an operation leaves SL set
    p_sv_sets_sl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we_i) |=> (!status_o[ST_SV] || status_o[ST_SL]));

    // R11: idle and undefined opcodes change nothing
    p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_NOP || op_i > 3'd4) && !sw_we_i) |=>
        ($stable(acc_o) && $stable(status_o)));

    // R2: load clears E, SV and C
    p_load_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LOAD && !sw_we_i) |=>
        (!status_o[ST_E] && !status_o[ST_SV] && !status_o[ST_C]));

    // R8: the two top bits always read zero
    p_top_bits_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[15:14] == 2'b00);
endmodule

bind mac_acc_unit mac_acc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .sw_we_i  (sw_we_i),
    .acc_o    (acc_o),
    .status_o (status_o)
);

// File: tb/sim_mac_acc_unit.sv
module sim_mac_acc_unit;
    localparam int CLK_HALF = 10; // 50 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [15:0] opa_i = '0, opb_i = '0;
    logic [2:0]  shamt_i = '0;
    logic        sw_we_i = 1'b0;
    logic [15:0] sw_wdata_i = '0;
    logic        ctl_we_i = 1'b0, ctl_sat_i = 1'b0;
    logic [39:0] acc_o;
    logic [15:0] status_o;
    logic        sat_en_o;

    always #CLK_HALF clk = ~clk;

    mac_acc_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
        .shamt_i(shamt_i), .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i),
        .ctl_we_i(ctl_we_i), .ctl_sat_i(ctl_sat_i),
        .acc_o(acc_o), .status_o(status_o), .sat_en_o(sat_en_o)
    );

    typedef struct {
        logic [39:0] acc;
        logic [15:0] st;
        logic        sat;
        string       tag;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state built from the requirements
    logic [39:0] m_acc = '0;
    logic m_n = 0, m_z = 0, m_c = 0, m_e = 0, m_sv = 0, m_sl = 0, m_sat = 0;

    function automatic logic ext_used(input logic [39:0] v);
        return !(v[39:31] == 9'h000 || v[39:31] == 9'h1FF);
    endfunction

    function automatic logic [15:0] m_status();
        return {2'b00, m_sl, m_sv, m_e, m_c, m_z, m_n, m_acc[39:32]};
    endfunction

    task automatic check(input logic [39:0] acc, input logic [15:0] st,
                         input logic sat, input exp_t x);
        n_cmp++;
        if (acc !== x.acc || st !== x.st || sat !== x.sat) begin
            n_bad++;
            $display("FAIL %s: acc=%h st=%h sat=%b expected acc=%h st=%h sat=%b",
                     x.tag, acc, st, sat, x.acc, x.st, x.sat);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic [2:0] sh, input logic swe, input logic [15:0] swd,
                         input logic cwe, input logic csat, input string tag);
        logic [39:0] opx;
        logic signed [40:0] t;
        int cnt;
        exp_t x;
        @(negedge clk);
        op_i = op; opa_i = a; opb_i = b; shamt_i = sh;
        sw_we_i = swe; sw_wdata_i = swd; ctl_we_i = cwe; ctl_sat_i = csat;
        opx = {{8{b[15]}}, b, a};
        if (swe) begin
            m_acc[39:32] = swd[7:0];
            m_n = swd[8]; m_z = swd[9]; m_c = swd[10];
            m_e = swd[11]; m_sv = swd[12]; m_sl = swd[13];
        end else begin
            case (op)
                3'd1: begin
                    m_acc = opx; m_n = opx[39]; m_z = (opx == 0);
                    m_c = 0; m_sv = 0; m_e = 0;
                end
                3'd2: begin
                    t = $signed({m_acc[39], m_acc}) - $signed({opx[39], opx});
                    m_sv = (t[40] != t[39]);
                    m_n = t[39]; m_z = (t[39:0] == 0);
                    m_c = (m_acc < opx);
                    m_sl = m_sl | m_sv;
                end
                3'd3, 3'd4: begin
                    cnt = int'(sh) + 1;
                    m_c = m_acc[cnt-1];
                    if (op == 3'd3) m_acc = m_acc >> cnt;
                    else m_acc = 40'($signed(m_acc) >>> cnt);
                    m_n = m_acc[39]; m_z = (m_acc == 0);
                    m_e = ext_used(m_acc); m_sv = 0;
                end
                default: ;
            endcase
        end
        if (cwe) m_sat = csat;
        @(posedge clk);
        #2;
        x.acc = m_acc; x.st = m_status(); x.sat = m_sat; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic op_only(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                           input logic [2:0] sh, input string tag);
        drive(op, a, b, sh, 1'b0, 16'h0, 1'b0, 1'b0, tag);
    endtask

    // monitor: pops one expectation per cycle after the edge that produced it
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            check(acc_o, status_o, sat_en_o, x);
        end
    end

    initial begin
        #(CLK_HALF * 2 * 100000);
        n_bad++;
        $display("FAIL watchdog: acc=%h st=%h expected run to finish", acc_o, status_o);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        r.acc = '0; r.st = '0; r.sat = 1'b0; r.tag = "R1 reset state";
        check(acc_o, status_o, sat_en_o, r);

        // load and compare ordering
        op_only(3'd1, 16'h0000, 16'h0007, 3'd0, "R2 load 0/7");
        op_only(3'd2, 16'h0000, 16'h0006, 3'd0, "R3 compare acc greater");
        op_only(3'd2, 16'h0000, 16'h0007, 3'd0, "R3 compare equal");
        op_only(3'd2, 16'h0000, 16'h0008, 3'd0, "R3 compare acc smaller");
        op_only(3'd1, 16'h0000, 16'h8000, 3'd0, "R2 load negative");

        // shift with saturation enabled, 0x7F extension
        op_only(3'd1, 16'h5555, 16'h5555, 3'd0, "R2 load 5555");
        drive(3'd0, 16'h0, 16'h0, 3'd0, 1'b1, 16'h007F, 1'b1, 1'b1, "R9 R12 write ext 7F, sat on");
        op_only(3'd3, 16'h0, 16'h0, 3'd0, "R4 R6 R7 logical shift by 1, sat on");
        op_only(3'd1, 16'h0000, 16'h8000, 3'd0, "R2 reload negative");
        op_only(3'd4, 16'h0, 16'h0, 3'd7, "R5 arithmetic shift by 8, sat on");
        op_only(3'd3, 16'h0, 16'h0, 3'd7, "R4 R7 logical shift by 8, sat on");

        // same shifts with saturation off
        drive(3'd1, 16'h0000, 16'h8000, 3'd0, 1'b0, 16'h0, 1'b1, 1'b0, "R12 sat off with load");
        op_only(3'd4, 16'h0, 16'h0, 3'd7, "R5 R6 arithmetic shift by 8, sat off");
        op_only(3'd3, 16'h0, 16'h0, 3'd7, "R4 R6 logical shift by 8, sat off");
        op_only(3'd1, 16'h5555, 16'h5555, 3'd0, "R2 load 5555 again");
        drive(3'd0, 16'h0, 16'h0, 3'd0, 1'b1, 16'h007F, 1'b0, 1'b0, "R9 write ext 7F");
        op_only(3'd3, 16'h0, 16'h0, 3'd0, "R6 R7 logical shift by 1, sat off");

        // overflow and sticky limit
        op_only(3'd1, 16'hFFFF, 16'hFFFF, 3'd0, "R2 load all ones");
        drive(3'd0, 16'h0, 16'h0, 3'd0, 1'b1, 16'h007F, 1'b0, 1'b0, "R9 write ext 7F");
        op_only(3'd2, 16'hFFFF, 16'hFFFF, 3'd0, "R3 R10 compare overflow");
        op_only(3'd1, 16'h1234, 16'h0001, 3'd0, "R10 load keeps SL");
        op_only(3'd6, 16'hAAAA, 16'hAAAA, 3'd5, "R11 undefined opcode");
        op_only(3'd0, 16'hAAAA, 16'hAAAA, 3'd5, "R11 idle opcode");
        drive(3'd0, 16'h0, 16'h0, 3'd0, 1'b1, 16'h0000, 1'b0, 1'b0, "R10 status write clears SL");

        // status write priority and layout
        drive(3'd1, 16'hFFFF, 16'hFFFF, 3'd0, 1'b1, 16'hFFAB, 1'b0, 1'b0, "R8 R9 write wins over load");
        op_only(3'd4, 16'h0, 16'h0, 3'd2, "R5 arithmetic shift by 3 of AB ext");

        @(negedge clk);
        op_i = 3'd0; sw_we_i = 1'b0; ctl_we_i = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule